// File: doc/BRIEF.md
# Serial Clock-Chip Register Loader

This block programs an external clock-conditioning device over a three-wire serial link made of a serial clock, a data line and a latch strobe. A single start pulse launches a fixed programming run. The run first sends a reset word, then fourteen configured register values. Each value is read from a configuration store with a 16-bit read port and is built from two halves. The half at the even offset supplies bits 31..16 and the half at the odd offset supplies bits 15..0.

Each 32-bit word is shifted out most significant bit first. Data moves only when the serial clock falls, so the device can sample on the rising edge. After the 32nd bit the clock stays low while the latch strobe is held high for one full serial period. While one word is being shifted, the two store reads for the next word are already done. Words therefore follow one another with nothing between them but the latch period. The serial clock is the system clock divided by an integer derived from two frequency parameters, which by default give 2 MHz from 50 MHz. The block reports busy for the whole run and a one-cycle done pulse at its end.

Top module: `ccfg_loader`

## Requirements
- R1: Directly after reset, busy, done, the store read strobe, serial clock, serial data and latch are all low.
- R2: A start sampled high while the block is idle begins a run, and busy is high from the cycle after the start was sampled.
- R3: A start sampled while a run is in progress, or in the cycle busy falls, is ignored: that run still sends exactly 15 words, and no further run follows.
- R4: The first word of every run is 0x80000000.
- R5: Word k (k = 1..14) equals {store[BASE+2k-2], store[BASE+2k-1]}. The even-offset half gives bits 31..16 and the odd-offset half gives bits 15..0.
- R6: Each word is sent MSB first as exactly 32 rising serial-clock edges, and the data line never changes while the serial clock is high.
- R7: Within a word, consecutive rising serial-clock edges are DIV = SYS_HZ/SER_HZ system cycles apart (25 by default), and each high phase lasts DIV - DIV/2 cycles (13).
- R8: After every word, the latch is high for exactly DIV cycles and the serial clock stays low while it is high. A run gives exactly 15 latch pulses.
- R9: Consecutive latch rising edges within a run are exactly 33*DIV system cycles apart, with no extra gap between words.
- R10: Busy falls, and done is high for exactly one cycle, in the same cycle that the last latch pulse ends. Earlier latch pulses end with busy still high.
- R11: The store is read with a one-cycle read latency, so data is expected in the cycle after the strobe. A run makes exactly 28 read cycles, all at addresses in [BASE, BASE+27].
- R12: A start held high across the end of a run starts a new run, with busy low for exactly two cycles between the two runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled each cycle |
| busy_o | output | 1 | High while a programming run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| cfg_rd_o | output | 1 | Store read strobe |
| cfg_addr_o | output | ADDR_W | Store read address |
| cfg_rdata_i | input | WORD_W/2 | Store read data, valid the cycle after the strobe |
| mw_clk_o | output | 1 | Serial clock, idle low |
| mw_data_o | output | 1 | Serial data, MSB first |
| mw_le_o | output | 1 | Latch strobe, high for one serial period after each word |

## Verification
Two events can fall in the same cycle: the end of the final latch pulse, where busy drops and done pulses, and a new start request. The bench provokes this overlap by holding start high across the end of a run. It checks that the request is not taken in the cycle busy falls, that busy stays low for exactly two samples, and that the second run then delivers a correct word stream. A second overlap, a start pulse in the middle of a run alongside the running shift and prefetch, is judged by a run that still has exactly 15 words, correct contents, unbroken 33-period latch spacing and no extra run afterwards.

// File: rtl/ccfg_pkg.sv
`timescale 1ns/1ps
package ccfg_pkg;

  // Prefetch engine states: two back-to-back reads, then capture
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ_HI,
    FS_REQ_LO,
    FS_CAP_LO
  } fetch_st_e;

  // Integer divide ratio from system clock to serial clock
  function automatic int unsigned ser_div(input int unsigned sys_hz,
                                          input int unsigned ser_hz);
    return sys_hz / ser_hz;
  endfunction

endpackage

// File: rtl/ccfg_phase.sv
`timescale 1ns/1ps
module ccfg_phase #(
  parameter int DIV = 25,
  parameter int LO  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick,
  output logic hi
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (clr) begin
      ph <= '0;
    end else if (run) begin
      if (ph == PH_W'(DIV - 1)) ph <= '0;
      else                      ph <= ph + 1'b1;
    end
  end

  // end of a serial period, and the high half of the period
  assign tick = run && (ph == PH_W'(DIV - 1));
  assign hi   = (ph >= PH_W'(LO));

  // R7: phase counter never leaves its period
  p_phase_range_r7: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_W'(DIV - 1));

endmodule

// File: rtl/ccfg_fetch.sv
`timescale 1ns/1ps
module ccfg_fetch
  import ccfg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          HALF_W    = 16,
  parameter int          IDX_W     = 4,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig,
  input  logic [IDX_W-1:0]    idx,
  output logic                rd_o,
  output logic [ADDR_W-1:0]   addr_o,
  input  logic [HALF_W-1:0]   rdata_i,
  output logic [2*HALF_W-1:0] word_o,
  output logic                valid_o
);
  fetch_st_e           st;
  logic [ADDR_W-1:0]   hi_addr;
  logic [HALF_W-1:0]   hi_buf;
  logic [HALF_W-1:0]   lo_buf;

  // word k lives at BASE + 2(k-1) (upper half) and the next address (lower)
  always_comb begin
    hi_addr = ADDR_W'(BASE_ADDR) + (ADDR_W'(idx) << 1) - ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      rd_o    <= 1'b0;
      addr_o  <= '0;
      hi_buf  <= '0;
      lo_buf  <= '0;
      valid_o <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: begin
          if (trig) begin
            addr_o  <= hi_addr;
            rd_o    <= 1'b1;
            valid_o <= 1'b0;
            st      <= FS_REQ_HI;
          end
        end
        FS_REQ_HI: begin
          addr_o <= addr_o + 1'b1;
          st     <= FS_REQ_LO;
        end
        FS_REQ_LO: begin
          hi_buf <= rdata_i;
          rd_o   <= 1'b0;
          st     <= FS_CAP_LO;
        end
        default: begin
          lo_buf  <= rdata_i;
          valid_o <= 1'b1;
          st      <= FS_IDLE;
        end
      endcase
    end
  end

  assign word_o = {hi_buf, lo_buf};

  // R11: a new prefetch is only requested when the previous one is complete
  p_fetch_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    trig |-> (st == FS_IDLE));

  // R11: reads come in pairs of two consecutive cycles
  p_rd_pair_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_o) |=> rd_o);

endmodule

// File: rtl/ccfg_shift.sv
`timescale 1ns/1ps
module ccfg_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              tick,
  input  logic              hi,
  output logic              in_latch,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o
);
  localparam int BC_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [BC_W-1:0]   bidx;

  // bidx counts bit slots; slot WORD_W is the latch slot
  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      bidx <= '0;
    end else if (ld) begin
      sh   <= ld_word;
      bidx <= '0;
    end else if (tick && (bidx != BC_W'(WORD_W))) begin
      sh   <= {sh[WORD_W-2:0], 1'b0};
      bidx <= bidx + 1'b1;
    end
  end

  assign in_latch = (bidx == BC_W'(WORD_W));

  // registered pins: data and clock low both change at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      le_o    <= 1'b0;
    end else begin
      sclk_o  <= run && !in_latch && hi;
      sdata_o <= run && !in_latch && sh[WORD_W-1];
      le_o    <= run && in_latch;
    end
  end

  // R8: latch strobe only while the serial clock is idle low
  p_le_no_sclk_r8: assert property (@(posedge clk) disable iff (rst)
    le_o |-> !sclk_o);

  // R6: data held steady across a serial-clock high phase
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

endmodule

// File: rtl/ccfg_loader.sv
`timescale 1ns/1ps
module ccfg_loader
  import ccfg_pkg::*;
#(
  parameter int unsigned       SYS_HZ     = 50_000_000,
  parameter int unsigned       SER_HZ     = 2_000_000,
  parameter int                WORD_W     = 32,
  parameter int                N_WORDS    = 15,
  parameter int                ADDR_W     = 12,
  parameter int unsigned       BASE_ADDR  = 0,
  parameter logic [WORD_W-1:0] RESET_WORD = 32'h8000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  cfg_rd_o,
  output logic [ADDR_W-1:0]     cfg_addr_o,
  input  logic [WORD_W/2-1:0]   cfg_rdata_i,
  output logic                  mw_clk_o,
  output logic                  mw_data_o,
  output logic                  mw_le_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int DIV    = int'(ser_div(SYS_HZ, SER_HZ));
  localparam int LO     = DIV / 2;
  localparam int IDX_W  = $clog2(N_WORDS);

  logic              run;
  logic [IDX_W-1:0]  widx;
  logic              accept;
  logic              tick;
  logic              hi;
  logic              in_latch;
  logic              word_end;
  logic              last;
  logic              finish;
  logic              advance;
  logic              pf_trig;
  logic [IDX_W-1:0]  pf_idx;
  logic [WORD_W-1:0] pf_word;
  logic              pf_valid;
  logic              ld;
  logic [WORD_W-1:0] ld_word;

  // sequencing decisions
  assign accept   = start_i && !run && !busy_o;
  assign word_end = tick && in_latch;
  assign last     = (widx == IDX_W'(N_WORDS - 1));
  assign finish   = word_end && last;
  assign advance  = word_end && !last;
  assign ld       = accept || advance;
  assign ld_word  = accept ? RESET_WORD : pf_word;
  assign pf_trig  = accept || (advance && ((int'(widx) + 2) < N_WORDS));
  assign pf_idx   = accept ? IDX_W'(1) : (widx + IDX_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      widx <= '0;
    end else if (accept) begin
      run  <= 1'b1;
      widx <= '0;
    end else if (finish) begin
      run  <= 1'b0;
    end else if (advance) begin
      widx <= widx + 1'b1;
    end
  end

  // status aligned with the one-cycle pin register
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_o <= run;
      done_o <= busy_o && !run;
    end
  end

  ccfg_phase #(
    .DIV (DIV),
    .LO  (LO)
  ) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .run  (run),
    .tick (tick),
    .hi   (hi)
  );

  ccfg_fetch #(
    .ADDR_W    (ADDR_W),
    .HALF_W    (HALF_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .trig    (pf_trig),
    .idx     (pf_idx),
    .rd_o    (cfg_rd_o),
    .addr_o  (cfg_addr_o),
    .rdata_i (cfg_rdata_i),
    .word_o  (pf_word),
    .valid_o (pf_valid)
  );

  ccfg_shift #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .ld       (ld),
    .ld_word  (ld_word),
    .tick     (tick),
    .hi       (hi),
    .in_latch (in_latch),
    .sclk_o   (mw_clk_o),
    .sdata_o  (mw_data_o),
    .le_o     (mw_le_o)
  );

  // R9: the next word is ready in the prefetch buffer when its slot begins
  p_word_ready_r9: assert property (@(posedge clk) disable iff (rst)
    advance |-> pf_valid);

  // R10: done is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: done marks the fall of busy
  p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: every latch pulse lies inside the busy window
  p_le_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mw_le_o |-> busy_o);

endmodule

// File: tb/ccfg_loader_tb.sv
`timescale 1ns/1ps
module ccfg_loader_tb;
  localparam int CLK_PERIOD = 20;
  localparam int DIV        = 25;
  localparam int LO         = 12;
  localparam int NW         = 15;
  localparam int BASE       = 32;
  localparam int WD_LIMIT   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, cfg_rd, mw_clk, mw_data, mw_le;
  logic [11:0] cfg_addr;
  logic [15:0] cfg_rdata = '0;
  logic [15:0] store [0:63];

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int seq_done = 0;
  bit wd_fired = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccfg_loader #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
    .cfg_rd_o(cfg_rd), .cfg_addr_o(cfg_addr), .cfg_rdata_i(cfg_rdata),
    .mw_clk_o(mw_clk), .mw_data_o(mw_data), .mw_le_o(mw_le)
  );

  // synchronous store, one-cycle read latency
  always @(posedge clk) if (cfg_rd) cfg_rdata <= store[cfg_addr[5:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k);
    if (k == 0) return 32'h8000_0000;
    return {store[BASE + 2*k - 2], store[BASE + 2*k - 1]};
  endfunction

  // monitor state
  logic        p_clk = 0, p_data = 0, p_le = 0;
  logic [31:0] cur = '0;
  logic [31:0] rx   [0:15];
  logic [31:0] s_rx [0:15];
  int nbits = 0, nrx = 0, nrd = 0, s_nrx = 0, s_nrd = 0;
  int last_rise = 0, hi_start = 0, last_le = 0, le_start = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mw_clk && !p_clk) begin
        if (nbits > 0) chk(cyc - last_rise == DIV, "R7", "serial period", cyc - last_rise, DIV);
        last_rise = cyc;
        hi_start  = cyc;
        cur   = {cur[30:0], mw_data};
        nbits++;
      end
      if (!mw_clk && p_clk)
        chk(cyc - hi_start == DIV - LO, "R7", "clock high time", cyc - hi_start, DIV - LO);
      if (mw_clk && p_clk && (mw_data != p_data))
        chk(1'b0, "R6", "data moved while clock high", mw_data, p_data);
      if (mw_le && mw_clk)
        chk(1'b0, "R8", "clock high during latch", 1, 0);
      if (mw_le && !p_le) begin
        chk(nbits == 32, "R6", "bits per word", nbits, 32);
        if (nrx < 16) rx[nrx] = cur;
        if (nrx > 0) chk(cyc - last_le == 33*DIV, "R9", "latch spacing", cyc - last_le, 33*DIV);
        nrx++;
        nbits    = 0;
        last_le  = cyc;
        le_start = cyc;
      end
      if (!mw_le && p_le) begin
        chk(cyc - le_start == DIV, "R8", "latch width", cyc - le_start, DIV);
        if (nrx == NW) chk(!busy && done, "R10", "busy/done at last latch end", {busy, done}, 2'b01);
        else           chk(busy && !done, "R10", "busy/done at inner latch end", {busy, done}, 2'b10);
      end
      if (cfg_rd) begin
        nrd++;
        chk(cfg_addr >= 12'(BASE) && cfg_addr < 12'(BASE + 28), "R11", "read address", cfg_addr, BASE);
      end
      if (done) begin
        chk(p_le && !mw_le, "R10", "done with latch fall", {p_le, mw_le}, 2'b10);
        for (int i = 0; i < 16; i++) s_rx[i] = rx[i];
        s_nrx = nrx;
        s_nrd = nrd;
        nrx = 0; nbits = 0; nrd = 0;
        seq_done++;
      end
    end
    p_clk  = mw_clk;
    p_data = mw_data;
    p_le   = mw_le;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  always @(negedge clk) begin
    if (cyc > WD_LIMIT && !wd_fired) begin
      wd_fired = 1'b1;
      chk(1'b0, "R2", "watchdog expired", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic wait_done();
    int base_cnt = seq_done;
    while (seq_done == base_cnt) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_start(input bit check_busy);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); #1;
    if (check_busy) chk(busy == 1'b1, "R2", "busy after start", busy, 1);
  endtask

  task automatic verify_seq(input string tag);
    chk(s_nrx == NW, "R8", {tag, " latch pulses"}, s_nrx, NW);
    chk(s_rx[0] == exp_word(0), "R4", {tag, " reset word"}, s_rx[0], exp_word(0));
    for (int k = 1; k < NW; k++)
      chk(s_rx[k] == exp_word(k), "R5", {tag, " configured word"}, s_rx[k], exp_word(k));
    chk(s_nrd == 28, "R11", {tag, " read cycles"}, s_nrd, 28);
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < 64; i++)
      store[i] = (mode == 0) ? 16'h0000 : (mode == 1) ? 16'hFFFF : 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd5489));
    fill(2);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk({busy, done, cfg_rd, mw_clk, mw_data, mw_le} == 6'b0, "R1", "outputs after reset",
        {busy, done, cfg_rd, mw_clk, mw_data, mw_le}, 0);
    repeat (10) @(negedge clk);
    #1;
    chk({busy, mw_clk, mw_le} == 3'b0, "R1", "idle without start", {busy, mw_clk, mw_le}, 0);

    // random contents
    pulse_start(1'b1); wait_done(); verify_seq("random");
    // all-zero and all-one halves
    fill(0); pulse_start(1'b1); wait_done(); verify_seq("zeros");
    fill(1); pulse_start(1'b1); wait_done(); verify_seq("ones");

    // R3: start pulses while busy are ignored
    fill(2);
    pulse_start(1'b1);
    repeat (3000) @(negedge clk);
    pulse_start(1'b0);
    chk(busy == 1'b1, "R3", "busy kept after ignored start", busy, 1);
    repeat (int'($urandom_range(2000, 4000))) @(negedge clk);
    pulse_start(1'b0);
    wait_done(); verify_seq("ignored-start");
    repeat (50) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R3", "no extra run after ignored starts", busy, 0);

    // R12: start held across the end of a run
    fill(2);
    @(negedge clk); start = 1'b1;
    wait_done(); verify_seq("held-first");
    @(negedge clk); #1;
    chk(busy == 1'b0, "R12", "busy low second cycle", busy, 0);
    @(negedge clk); #1;
    chk(busy == 1'b1, "R12", "busy back after two cycles", busy, 1);
    start = 1'b0;
    wait_done(); verify_seq("R12 held-second");
    repeat (20) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R3", "idle after held-start pair", busy, 0);

    finish_run();
  end

endmodule